// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash and runs the device's embedded write algorithms by itself. A single start pulse launches one of two jobs. The first programs a run of consecutive bytes, taken one at a time from a ready/valid byte source, beginning at a given address. The second erases the whole chip. For every byte, and once for an erase, the block emits the unlock and command write cycles and then polls the device until the internal operation has finished.

All bus timing is given in clock cycles through parameters: address and data setup, write strobe low width, write strobe recovery, and read access. Completion is found in one of two ways, chosen by an input. The first reads the target location until bit 7 shows the true data. The second reads twice in a row until bit 6 stops alternating. A cycle counter bounds each wait. If the counter expires, the job is abandoned and an error is reported with the completion pulse.

Top module: `flash_prog_seq`

## Requirements
- R1: While and after reset, with no start, the write, read and select strobes are high (inactive), the data drive enable is 0, and busy and byte request are 0.
- R2: Programming one byte issues exactly four write cycles in this order: data AAh at address 05555h, 55h at 02AAAh, A0h at 05555h, then the byte at its target address.
- R3: A chip erase issues exactly six write cycles in this order: AAh/05555h, 55h/02AAAh, 80h/05555h, AAh/05555h, 55h/02AAAh, 10h/05555h. It requests no bytes.
- R4: Each write strobe stays low for at least WE_LOW_CYC cycles. Two strobes are separated by at least WE_HIGH_CYC high cycles. Address and write data do not change while the strobe is low.
- R5: The read strobe is high during every write cycle. The data drive enable is 0 whenever the read strobe is low.
- R6: With poll_toggle_i = 0, the block reads the target address after the command writes. It treats the operation as finished only when read bit 7 equals the true bit 7 of the data (1 for an erase). No further write is issued before that.
- R7: With poll_toggle_i = 1, the block treats the operation as finished only when two consecutive reads return the same bit 6. No further write is issued before that.
- R8: The target address increments by one after each completed byte. A new byte is requested (byte_ready_o = 1) only while busy and waiting for data. Exactly len_i bytes are consumed, then done_o pulses for one cycle with err_o = 0.
- R9: If completion is not seen within PROG_TO_CYC cycles of the last command write (ERASE_TO_CYC for an erase), done_o and err_o pulse together. The remaining bytes are neither requested nor written.
- R10: A program start with len_i = 0 issues no bus cycle and pulses done_o.
- R11: A start pulse while busy is ignored. No bus cycle it would cause appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle job launch, taken only when idle |
| op_erase_i | input | 1 | 1: chip erase, 0: program a byte run |
| poll_toggle_i | input | 1 | 1: toggle-bit polling, 0: data-bit polling |
| addr_i | input | AW | First target address |
| len_i | input | LW | Number of bytes to program |
| byte_valid_i | input | 1 | Byte source has data |
| byte_data_i | input | 8 | Byte to program |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| err_o | output | 1 | Timeout, valid with done_o |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash data bus, driven value |
| fl_dq_oe_o | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Flash data bus, sampled value |
| fl_we_n_o | output | 1 | Write strobe, active low |
| fl_oe_n_o | output | 1 | Read strobe, active low |
| fl_ce_n_o | output | 1 | Chip select, active low |

## Verification
The hardest case to reach from the ports is a device that never finishes while the run still has unsent bytes. Only then do the timeout, the abort and the refusal to request more data all show up. The bench contains a behavioural flash that decodes the command writes and answers a set number of polls with the busy pattern: bit 7 inverted or zero, and bit 6 alternating. A stuck switch keeps it busy forever. A three-byte program against the stuck model must end after four writes, with the error flag set and two bytes left unrequested. The same model catches early completion, because it flags any write that arrives while it still reports busy.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_CMD,
    S_POLL
  } seq_st_t;

  typedef enum logic [1:0] {
    B_IDLE,
    B_SETUP,
    B_STROBE,
    B_RECOV
  } bus_st_t;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  // data byte of command write number s (program: 0..3, erase: 0..5)
  function automatic logic [7:0] cmd_data(input logic er, input logic [2:0] s,
                                          input logic [7:0] d);
    logic [7:0] r;
    case (s)
      3'd0:    r = 8'hAA;
      3'd1:    r = 8'h55;
      3'd2:    r = er ? 8'h80 : 8'hA0;
      3'd3:    r = er ? 8'hAA : d;
      3'd4:    r = 8'h55;
      default: r = 8'h10;
    endcase
    return r;
  endfunction

  function automatic logic cmd_is_target(input logic er, input logic [2:0] s);
    return !er && (s == 3'd3);
  endfunction

  function automatic logic cmd_is_b(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd4);
  endfunction

endpackage

// File: rtl/fps_bus_cycle.sv
module fps_bus_cycle
  import fps_pkg::*;
#(
  parameter int AW          = 18,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 13,
  parameter int WE_HIGH_CYC = 13,
  parameter int HOLD_CYC    = 7,
  parameter int READ_CYC    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_ce_n
);

  localparam int RCV_CYC = (HOLD_CYC > WE_HIGH_CYC) ? HOLD_CYC : WE_HIGH_CYC;
  localparam int M1      = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int M2      = (READ_CYC > RCV_CYC) ? READ_CYC : RCV_CYC;
  localparam int MAXC    = (M1 > M2) ? M1 : M2;
  localparam int CW      = $clog2(MAXC + 1);

  bus_st_t       st;
  logic [CW-1:0] cnt;
  logic          is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      ack      <= 1'b0;
      rdata    <= '0;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
      fl_we_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_ce_n  <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (st)
        B_IDLE: if (go) begin
          is_wr    <= wr;
          fl_addr  <= addr;
          fl_dq_o  <= wdata;
          fl_dq_oe <= wr;
          fl_ce_n  <= 1'b0;
          cnt      <= CW'(SETUP_CYC - 1);
          st       <= B_SETUP;
        end
        B_SETUP: begin
          if (cnt == '0) begin
            if (is_wr) begin
              fl_we_n <= 1'b0;
              cnt     <= CW'(WE_LOW_CYC - 1);
            end else begin
              fl_oe_n <= 1'b0;
              cnt     <= CW'(READ_CYC - 1);
            end
            st <= B_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_STROBE: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            if (!is_wr) rdata <= fl_dq_i;
            cnt <= CW'(RCV_CYC - 1);
            st  <= B_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            ack      <= 1'b1;
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            st       <= B_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // strobe-width observation counter
  logic [CW:0] lo_run;
  always_ff @(posedge clk) begin
    if (rst) lo_run <= '0;
    else if (!fl_we_n) lo_run <= lo_run + 1'b1;
    else lo_run <= '0;
  end

  // R4
  we_low_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (lo_run >= (CW+1)'(WE_LOW_CYC)));

  // R4
  wr_bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

  // R5
  no_drive_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);

  // R5
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_oe_n);

endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
  parameter int PROG_TO_CYC  = 6250,
  parameter int ERASE_TO_CYC = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sel_erase,
  output logic expired
);

  localparam int MAXT = (PROG_TO_CYC > ERASE_TO_CYC) ? PROG_TO_CYC : ERASE_TO_CYC;
  localparam int TW   = $clog2(MAXT + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit = sel_erase ? TW'(ERASE_TO_CYC) : TW'(PROG_TO_CYC);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      cnt     <= cnt + 1'b1;
      expired <= (cnt + 1'b1) >= limit;
    end
  end

  // R9
  expire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !clear) |=> expired);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW           = 18,
  parameter int LW           = AW + 1,
  parameter int SETUP_CYC    = 1,
  parameter int WE_LOW_CYC   = 13,
  parameter int WE_HIGH_CYC  = 13,
  parameter int HOLD_CYC     = 7,
  parameter int READ_CYC     = 12,
  parameter int PROG_TO_CYC  = 6250,
  parameter int ERASE_TO_CYC = 125_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          poll_toggle_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  output logic          byte_ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_we_n_o,
  output logic          fl_oe_n_o,
  output logic          fl_ce_n_o
);

  seq_st_t       st;
  logic          op_er, tog_mode;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] remain;
  logic [7:0]    cur_data;
  logic [2:0]    step;
  logic          first_b6, have_first;

  logic          bus_go, bus_wr, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          tmr_clear, tmr_expired;

  logic [2:0]    last_step;
  logic          exp_b7, poll_ok;

  assign last_step = op_er ? 3'd5 : 3'd3;
  assign exp_b7    = op_er ? 1'b1 : cur_data[7];
  assign poll_ok   = tog_mode ? (have_first && (bus_rdata[6] == first_b6))
                              : (bus_rdata[7] == exp_b7);

  function automatic logic [AW-1:0] cmd_addr(input logic er, input logic [2:0] s,
                                             input logic [AW-1:0] tgt);
    if (cmd_is_target(er, s)) return tgt;
    else if (cmd_is_b(s)) return AW'(UNLOCK_B);
    else return AW'(UNLOCK_A);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      op_er        <= 1'b0;
      tog_mode     <= 1'b0;
      cur_addr     <= '0;
      remain       <= '0;
      cur_data     <= '0;
      step         <= '0;
      first_b6     <= 1'b0;
      have_first   <= 1'b0;
      bus_go       <= 1'b0;
      bus_wr       <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      tmr_clear    <= 1'b0;
      byte_ready_o <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      bus_go    <= 1'b0;
      tmr_clear <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          op_er    <= op_erase_i;
          tog_mode <= poll_toggle_i;
          cur_addr <= addr_i;
          remain   <= len_i;
          step     <= '0;
          if (!op_erase_i && len_i == '0) begin
            done_o <= 1'b1;
          end else if (op_erase_i) begin
            busy_o    <= 1'b1;
            bus_go    <= 1'b1;
            bus_wr    <= 1'b1;
            bus_addr  <= AW'(UNLOCK_A);
            bus_wdata <= cmd_data(1'b1, 3'd0, 8'h00);
            st        <= S_CMD;
          end else begin
            busy_o       <= 1'b1;
            byte_ready_o <= 1'b1;
            st           <= S_FETCH;
          end
        end
        S_FETCH: if (byte_valid_i) begin
          byte_ready_o <= 1'b0;
          cur_data     <= byte_data_i;
          step         <= '0;
          bus_go       <= 1'b1;
          bus_wr       <= 1'b1;
          bus_addr     <= AW'(UNLOCK_A);
          bus_wdata    <= cmd_data(1'b0, 3'd0, byte_data_i);
          st           <= S_CMD;
        end
        S_CMD: if (bus_ack) begin
          bus_go <= 1'b1;
          if (step == last_step) begin
            tmr_clear  <= 1'b1;
            have_first <= 1'b0;
            bus_wr     <= 1'b0;
            bus_addr   <= cur_addr;
            st         <= S_POLL;
          end else begin
            step      <= step + 1'b1;
            bus_wr    <= 1'b1;
            bus_addr  <= cmd_addr(op_er, step + 1'b1, cur_addr);
            bus_wdata <= cmd_data(op_er, step + 1'b1, cur_data);
          end
        end
        default: if (bus_ack) begin
          first_b6   <= bus_rdata[6];
          have_first <= 1'b1;
          if (poll_ok) begin
            if (op_er || remain == LW'(1)) begin
              done_o <= 1'b1;
              busy_o <= 1'b0;
              st     <= S_IDLE;
            end else begin
              cur_addr     <= cur_addr + 1'b1;
              remain       <= remain - 1'b1;
              byte_ready_o <= 1'b1;
              st           <= S_FETCH;
            end
          end else if (tmr_expired) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            busy_o <= 1'b0;
            st     <= S_IDLE;
          end else begin
            bus_go   <= 1'b1;
            bus_wr   <= 1'b0;
            bus_addr <= cur_addr;
          end
        end
      endcase
    end
  end

  fps_bus_cycle #(
    .AW(AW), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC), .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .go(bus_go), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ack(bus_ack), .rdata(bus_rdata),
    .fl_addr(fl_addr_o), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe_o),
    .fl_dq_i(fl_dq_i), .fl_we_n(fl_we_n_o), .fl_oe_n(fl_oe_n_o),
    .fl_ce_n(fl_ce_n_o)
  );

  fps_poll_timer #(
    .PROG_TO_CYC(PROG_TO_CYC), .ERASE_TO_CYC(ERASE_TO_CYC)
  ) u_tmr (
    .clk(clk), .rst(rst), .clear(tmr_clear), .sel_erase(op_er),
    .expired(tmr_expired)
  );

  // R8
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> busy_o);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

  localparam int AW = 18;
  localparam int LW = 19;
  localparam int WLO = 3;
  localparam int WHI = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start_i = 0, op_erase_i = 0, poll_toggle_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          byte_valid_i = 0;
  logic [7:0]    byte_data_i = '0;
  logic          byte_ready_o, busy_o, done_o, err_o;
  logic [AW-1:0] fl_addr_o;
  logic [7:0]    fl_dq_o, rd_val = '0;
  logic          fl_dq_oe_o, fl_we_n_o, fl_oe_n_o, fl_ce_n_o;

  flash_prog_seq #(
    .AW(AW), .LW(LW), .SETUP_CYC(1), .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI),
    .HOLD_CYC(2), .READ_CYC(2), .PROG_TO_CYC(300), .ERASE_TO_CYC(600)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_erase_i(op_erase_i),
    .poll_toggle_i(poll_toggle_i), .addr_i(addr_i), .len_i(len_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_ready_o(byte_ready_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fl_addr_o(fl_addr_o), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe_o),
    .fl_dq_i(rd_val), .fl_we_n_o(fl_we_n_o), .fl_oe_n_o(fl_oe_n_o),
    .fl_ce_n_o(fl_ce_n_o)
  );

  int checks = 0, errors = 0, n_writes = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected write cycles {addr,data}
  logic [AW+7:0] exp_q[$];
  task automatic push_prog(input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({18'h05555, 8'hAA});
    exp_q.push_back({18'h02AAA, 8'h55});
    exp_q.push_back({18'h05555, 8'hA0});
    exp_q.push_back({a, d});
  endtask
  task automatic push_erase();
    exp_q.push_back({18'h05555, 8'hAA});
    exp_q.push_back({18'h02AAA, 8'h55});
    exp_q.push_back({18'h05555, 8'h80});
    exp_q.push_back({18'h05555, 8'hAA});
    exp_q.push_back({18'h02AAA, 8'h55});
    exp_q.push_back({18'h05555, 8'h10});
  endtask

  // behavioural flash
  logic [AW-1:0] ha[0:4];
  logic [7:0]    hd[0:4];
  int            busy_cnt = 0;
  bit            stuck = 0, m_erase = 0, tog = 0, dpoll = 0;
  logic [7:0]    true_d = 8'hFF;
  logic [AW-1:0] tgt = '0;

  always @(posedge fl_we_n_o) if (!rst) begin
    logic [AW+7:0] e;
    n_writes++;
    if (exp_q.size() == 0) chk(0, "R2/R3/R11", "unexpected write", {fl_addr_o, fl_dq_o}, 0);
    else begin
      e = exp_q.pop_front();
      chk({fl_addr_o, fl_dq_o} == e, "R2/R3/R8", "write cycle", {fl_addr_o, fl_dq_o}, e);
    end
    chk(busy_cnt == 0, "R6/R7", "write while device busy", busy_cnt, 0);
    if (ha[2] == 18'h05555 && hd[2] == 8'hAA && ha[1] == 18'h02AAA && hd[1] == 8'h55 &&
        ha[0] == 18'h05555 && hd[0] == 8'hA0) begin
      busy_cnt = stuck ? 32'h7fffffff : 3; true_d = fl_dq_o; tgt = fl_addr_o; m_erase = 0;
    end
    if (fl_addr_o == 18'h05555 && fl_dq_o == 8'h10 && hd[0] == 8'h55 &&
        hd[1] == 8'hAA && hd[2] == 8'h80) begin
      busy_cnt = stuck ? 32'h7fffffff : 5; true_d = 8'hFF; m_erase = 1;
    end
    for (int i = 4; i > 0; i--) begin ha[i] = ha[i-1]; hd[i] = hd[i-1]; end
    ha[0] = fl_addr_o; hd[0] = fl_dq_o;
  end

  always @(negedge fl_oe_n_o) if (!rst && !fl_ce_n_o) begin
    if (busy_cnt > 0) begin
      rd_val = {m_erase ? 1'b0 : ~true_d[7], tog, 6'h00};
      tog = ~tog;
      busy_cnt--;
      if (dpoll && !m_erase) chk(fl_addr_o == tgt, "R6", "poll address", fl_addr_o, tgt);
    end else rd_val = true_d;
  end

  // bus timing monitor
  int lo_run = 0, hi_run = 0, contention = 0;
  bit seen_rise = 0;
  always @(negedge clk) if (!rst) begin
    if (!fl_oe_n_o && (fl_dq_oe_o || !fl_we_n_o)) contention++;
    if (!fl_we_n_o) begin
      if (lo_run == 0 && seen_rise) chk(hi_run >= WHI, "R4", "strobe high gap", hi_run, WHI);
      lo_run++; hi_run = 0;
    end else begin
      if (lo_run != 0) begin
        chk(lo_run >= WLO, "R4", "strobe low width", lo_run, WLO);
        seen_rise = 1;
      end
      lo_run = 0; hi_run++;
    end
  end

  // byte source
  logic [7:0] feed_q[$];
  bit fire = 0;
  always @(posedge clk) fire <= byte_valid_i && byte_ready_o;
  initial forever begin
    @(negedge clk);
    if (fire && feed_q.size() > 0) void'(feed_q.pop_front());
    byte_valid_i = feed_q.size() > 0;
    byte_data_i  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial forever begin
    @(posedge clk); cyc++;
    if (cyc > 150000) begin
      chk(0, "R8", "watchdog expired", cyc, 150000);
      summary(); $finish;
    end
  end

  task automatic launch(input bit er, input bit tg, input logic [AW-1:0] a, input int n);
    @(negedge clk);
    op_erase_i = er; poll_toggle_i = tg; addr_i = a; len_i = LW'(n); dpoll = !tg;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done(output bit e, input int lim);
    e = 1'bx;
    for (int i = 0; i < lim; i++) begin
      if (done_o) begin e = err_o; return; end
      @(negedge clk);
    end
    chk(0, "R8", "done not seen", 0, 1);
  endtask

  task automatic prog_run(input bit tg, input logic [AW-1:0] a, input logic [7:0] d[]);
    bit e;
    foreach (d[i]) begin feed_q.push_back(d[i]); push_prog(a + AW'(i), d[i]); end
    launch(0, tg, a, d.size());
    wait_done(e, 20000);
    chk(e == 0, tg ? "R7" : "R6", "err flag on good program", e, 0);
    chk(exp_q.size() == 0, "R8", "writes left over", exp_q.size(), 0);
    chk(feed_q.size() == 0, "R8", "bytes not consumed", feed_q.size(), 0);
  endtask

  initial begin
    bit e;
    int w0;
    for (int i = 0; i < 5; i++) begin ha[i] = '0; hd[i] = '0; end
    repeat (4) @(negedge clk);
    // R1
    chk(fl_we_n_o && fl_oe_n_o && fl_ce_n_o, "R1", "strobes in reset", {fl_we_n_o, fl_oe_n_o, fl_ce_n_o}, 3'b111);
    chk(!fl_dq_oe_o && !busy_o && !byte_ready_o, "R1", "drive/busy/ready in reset",
        {fl_dq_oe_o, busy_o, byte_ready_o}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(fl_we_n_o && fl_oe_n_o && !busy_o && !byte_ready_o, "R1", "idle after reset",
        {fl_we_n_o, fl_oe_n_o, busy_o, byte_ready_o}, 4'b1100);

    // R2 R6 R8 R11: data poll program, with a stray start while busy
    fork
      prog_run(0, 18'h01234, '{8'hA5, 8'h3C, 8'h7F});
      begin
        repeat (12) @(negedge clk);
        op_erase_i = 1; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(busy_o == 1, "R11", "busy during run", busy_o, 1);
      end
    join

    // R7 R8: toggle polling across the top of the address space
    prog_run(1, 18'h3FFFE, '{8'h40, 8'hBF});

    // R3 R6: erase, data polling
    push_erase();
    launch(1, 0, 18'h00000, 0);
    chk(byte_ready_o == 0, "R3", "byte request during erase", byte_ready_o, 0);
    wait_done(e, 20000);
    chk(e == 0 && exp_q.size() == 0, "R3", "erase data poll", {e, exp_q.size() == 0}, 1);

    // R3 R7: erase, toggle polling
    push_erase();
    launch(1, 1, 18'h00010, 0);
    wait_done(e, 20000);
    chk(e == 0 && exp_q.size() == 0, "R3", "erase toggle poll", {e, exp_q.size() == 0}, 1);

    // R10: zero-length program
    w0 = n_writes;
    launch(0, 0, 18'h00100, 0);
    wait_done(e, 10);
    chk(n_writes == w0 && e == 0, "R10", "zero length", n_writes - w0, 0);

    // R9: device never completes, three bytes offered
    stuck = 1;
    feed_q.push_back(8'h11); feed_q.push_back(8'h22); feed_q.push_back(8'h33);
    push_prog(18'h00200, 8'h11);
    launch(0, 0, 18'h00200, 3);
    wait_done(e, 5000);
    chk(e == 1, "R9", "timeout error", e, 1);
    repeat (40) begin
      @(negedge clk);
      if (byte_ready_o || busy_o) begin
        chk(0, "R9", "activity after abort", {byte_ready_o, busy_o}, 0);
        break;
      end
    end
    chk(feed_q.size() == 2 && exp_q.size() == 0, "R9", "bytes left unrequested", feed_q.size(), 2);
    feed_q.delete();
    rst = 1; stuck = 0; busy_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R5
    chk(contention == 0, "R5", "drive or write while read strobe low", contention, 0);
    summary();
    $finish;
  end

endmodule